// File: doc/BRIEF.md
# Per-Command Configurable Serial Shift Engine

This block moves serial data out of and into a chip over a clock line, a data-out line, a mode line and a data-in line. It has no fixed setup registers. Every transfer starts with a command byte, and that byte chooses the settings for that transfer only:

- the clock edge that launches outgoing bits;
- the clock edge that captures incoming bits;
- the bit order;
- bit or byte granularity;
- separate enables for the data-out line, the data-in line and the mode line.

Commands with different settings can follow each other with nothing in between.

A command arrives on a valid/ready handshake together with a length operand and a clock divisor. Outgoing bytes come in on a second valid/ready stream. Captured bytes leave on a third valid/ready stream. The serial clock runs at the system clock divided by 2×(divisor+1). The clock idles low, and each bit cell is a low half followed by a high half. When the output stream is not ready, the engine holds the serial clock still until the captured byte is taken.

Top module: `cmd_shift_engine`

## Requirements
- R1: After reset, and whenever no command is running, `ser_clk` is low, `rx_valid` is low and `cmd_ready` is high.
- R2: The high half of each bit cell lasts divisor+1 clock cycles. The low half between two bits of the same byte also lasts divisor+1 cycles. The divisor is taken when the command is accepted.
- R3: Command bit 0 = 0: `ser_out` takes each new bit on the rising `ser_clk` edge. Bit 0 = 1: the first bit is placed before the first rising edge and later bits change on falling edges. Either way, the bit is stable on the opposite edge.
- R4: Command bit 2 = 0: `ser_in` is captured on rising `ser_clk` edges. Bit 2 = 1: it is captured on falling edges.
- R5: Let n be the number of bits per byte. With command bit 3 = 0 (MSB first), the bits go out as data[n-1] down to data[0], and the first captured bit lands in bit n-1. With bit 3 = 1 (LSB first), the bits go out as data[0] up to data[n-1], and the first captured bit lands in bit 0. Captured bits above n-1 read as zero.
- R6: Command bit 1 = 0 is byte mode: the transfer is length+1 bytes of 8 bits each.
- R7: Command bit 1 = 1 is bit mode: the transfer is one byte of length[2:0]+1 bits, and the upper length bits are ignored.
- R8: Command bit 4 lets the engine drive `ser_out`. While it is clear, `ser_out` keeps its previous value.
- R9: Command bit 5 makes the engine send one captured byte on `rx_data` for each byte transferred. While it is clear, no byte is sent.
- R10: Command bit 6 drives `ser_mode` with the same bit stream. While it is clear, `ser_mode` keeps its value. One outgoing byte per transferred byte is taken from `tx_data` when bit 4 or bit 6 is set, and none when both are clear.
- R11: A command with bit 7 set is accepted and discarded: no clock edges and no outgoing byte is taken.
- R12: While `rx_valid` is high and `rx_ready` is low, `rx_data` is stable and `ser_clk` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken |
| cmd_byte | input | 8 | Command byte with per-transfer settings |
| cmd_len | input | LEN_W | Length operand (bytes-1 or bits-1) |
| cmd_div | input | DIV_W | Clock divisor for this transfer |
| tx_valid | input | 1 | Outgoing byte offered |
| tx_ready | output | 1 | Outgoing byte taken |
| tx_data | input | W | Outgoing byte |
| rx_valid | output | 1 | Captured byte available |
| rx_ready | input | 1 | Captured byte taken |
| rx_data | output | W | Captured byte |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_out | output | 1 | Serial data out |
| ser_mode | output | 1 | Serial mode line |
| ser_in | input | 1 | Serial data in |

## Verification
The hardest state to reach is a receive stall in the middle of a multi-byte transfer, where the engine has to freeze between bytes with the serial clock low. The same stall has to be reached under both capture edges and both bit orders. The bench gets there by holding `rx_ready` high only on every third cycle during read transfers. A slave model drives `ser_in` on the edge opposite the capture edge, so a wrong capture edge shows up as shifted bits. That model also measures every clock half-period against the divisor.

// File: rtl/cse_pkg.sv
package cse_pkg;

  // Command byte layout; bit positions are the per-transfer control fields.
  typedef struct packed {
    logic zero7;       // [7] must be clear for a serial transfer
    logic tms_en;      // [6] drive the mode line
    logic di_en;       // [5] capture and return input bytes
    logic do_en;       // [4] drive the data-out line
    logic lsb_first;   // [3] bit order
    logic cap_fall;    // [2] capture on falling edge
    logic bit_mode;    // [1] bit granularity
    logic launch_fall; // [0] launch on falling edge
  } cse_cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LOW,
    ST_HIGH,
    ST_EMIT
  } cse_state_t;

endpackage

// File: rtl/cse_half_timer.sv
module cse_half_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic [DIV_W-1:0] div_val,
  output logic             at_zero
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (reload) begin
      cnt <= div_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign at_zero = (cnt == '0);

endmodule

// File: rtl/cse_shift_path.sv
module cse_shift_path #(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [W-1:0]     load_data,
  input  logic             lsb_first,
  input  logic [IDX_W-1:0] nbits_m1,
  input  logic [IDX_W-1:0] sel_k,
  output logic             sel_bit,
  input  logic             cap_en,
  input  logic [IDX_W-1:0] cap_k,
  input  logic             sdi,
  output logic [W-1:0]     rx_next
);

  logic [W-1:0] tx_hold;
  logic [W-1:0] rx_acc;
  logic [W-1:0] src;

  function automatic logic [IDX_W-1:0] bit_pos(input logic [IDX_W-1:0] kk);
    return lsb_first ? kk : (nbits_m1 - kk);
  endfunction

  assign src     = load ? load_data : tx_hold;
  assign sel_bit = src[bit_pos(sel_k)];

  always_comb begin
    rx_next = rx_acc;
    if (cap_en) rx_next[bit_pos(cap_k)] = sdi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hold <= '0;
      rx_acc  <= '0;
    end else if (load) begin
      tx_hold <= load_data;
      rx_acc  <= '0;
    end else if (cap_en) begin
      rx_acc  <= rx_next;
    end
  end

  // R5: a capture never coincides with the start of a new byte
  p_no_cap_on_load_r5: assert property (@(posedge clk) disable iff (rst)
    load |-> !cap_en);

endmodule

// File: rtl/cmd_shift_engine.sv
module cmd_shift_engine
  import cse_pkg::*;
#(
  parameter int W     = 8,
  parameter int LEN_W = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_byte,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [DIV_W-1:0] cmd_div,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [W-1:0]     tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [W-1:0]     rx_data,
  output logic             ser_clk,
  output logic             ser_out,
  output logic             ser_mode,
  input  logic             ser_in
);

  localparam int IDX_W = $clog2(W);

  cse_state_t       state;
  cse_cmd_t         cmd_q;
  cse_cmd_t         cmd_in;
  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] bytes_left;
  logic [IDX_W-1:0] nbm1;
  logic [IDX_W-1:0] k;
  logic             sclk_q, sdo_q, stms_q, rxv_q;
  logic [W-1:0]     rxd_q;

  logic             need_tx, go_load, at_zero, rise, fall, last_bit;
  logic             launch_now, cap_en, reload;
  logic [IDX_W-1:0] sel_k;
  logic             sel_bit;
  logic [W-1:0]     rx_next;
  logic [W-1:0]     load_data;

  assign cmd_in    = cse_cmd_t'(cmd_byte);
  assign need_tx   = cmd_q.do_en | cmd_q.tms_en;
  assign cmd_ready = (state == ST_IDLE);
  assign tx_ready  = (state == ST_LOAD) && need_tx;
  assign go_load   = (state == ST_LOAD) && (!need_tx || tx_valid);
  assign rise      = (state == ST_LOW)  && at_zero;
  assign fall      = (state == ST_HIGH) && at_zero;
  assign last_bit  = (k == nbm1);
  assign load_data = need_tx ? tx_data : '0;

  assign sel_k      = go_load ? '0 : (rise ? k : k + 1'b1);
  assign launch_now = (go_load && cmd_q.launch_fall) ||
                      (rise && !cmd_q.launch_fall) ||
                      (fall && !last_bit && cmd_q.launch_fall);
  assign cap_en     = (rise && !cmd_q.cap_fall) || (fall && cmd_q.cap_fall);
  assign reload     = go_load || rise || (fall && !last_bit);

  cse_half_timer #(.DIV_W(DIV_W)) i_timer (
    .clk     (clk),
    .rst     (rst),
    .reload  (reload),
    .div_val (div_q),
    .at_zero (at_zero)
  );

  cse_shift_path #(.W(W), .IDX_W(IDX_W)) i_path (
    .clk       (clk),
    .rst       (rst),
    .load      (go_load),
    .load_data (load_data),
    .lsb_first (cmd_q.lsb_first),
    .nbits_m1  (nbm1),
    .sel_k     (sel_k),
    .sel_bit   (sel_bit),
    .cap_en    (cap_en),
    .cap_k     (k),
    .sdi       (ser_in),
    .rx_next   (rx_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cmd_q      <= '0;
      div_q      <= '0;
      bytes_left <= '0;
      nbm1       <= '0;
      k          <= '0;
      sclk_q     <= 1'b0;
      rxv_q      <= 1'b0;
      rxd_q      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            cmd_q <= cmd_in;
            div_q <= cmd_div;
            if (!cmd_in.zero7) begin
              bytes_left <= cmd_in.bit_mode ? '0 : cmd_len;
              nbm1       <= cmd_in.bit_mode ? cmd_len[IDX_W-1:0] : IDX_W'(W - 1);
              state      <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (go_load) begin
            k     <= '0;
            state <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (at_zero) begin
            sclk_q <= 1'b1;
            state  <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (at_zero) begin
            sclk_q <= 1'b0;
            if (!last_bit) begin
              k     <= k + 1'b1;
              state <= ST_LOW;
            end else if (cmd_q.di_en) begin
              rxv_q <= 1'b1;
              rxd_q <= rx_next;
              state <= ST_EMIT;
            end else if (bytes_left == '0) begin
              state <= ST_IDLE;
            end else begin
              bytes_left <= bytes_left - 1'b1;
              state      <= ST_LOAD;
            end
          end
        end
        ST_EMIT: begin
          if (rx_ready) begin
            rxv_q <= 1'b0;
            if (bytes_left == '0) begin
              state <= ST_IDLE;
            end else begin
              bytes_left <= bytes_left - 1'b1;
              state      <= ST_LOAD;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_q  <= 1'b0;
      stms_q <= 1'b0;
    end else if (launch_now) begin
      if (cmd_q.do_en)  sdo_q  <= sel_bit;
      if (cmd_q.tms_en) stms_q <= sel_bit;
    end
  end

  assign ser_clk  = sclk_q;
  assign ser_out  = sdo_q;
  assign ser_mode = stms_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;

  // R1: the clock is low whenever the engine is idle
  p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sclk_q);

  // R2: the serial clock only moves when a half period has expired
  p_edge_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk_q) |-> $past(at_zero));

  // R8: data-out holds while its enable is clear
  p_sdo_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && !cmd_q.do_en) |=> $stable(sdo_q));

  // R9: captured bytes only appear for commands that read
  p_rx_only_en_r9: assert property (@(posedge clk) disable iff (rst)
    rxv_q |-> cmd_q.di_en);

  // R10: the mode line holds while its enable is clear
  p_tms_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && !cmd_q.tms_en) |=> $stable(stms_q));

  // R11: a command with bit 7 set leaves the engine idle
  p_bit7_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && state == ST_IDLE && cmd_byte[7]) |=> (state == ST_IDLE));

  // R11: a running transfer never carries bit 7
  p_run_clean_r11: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !cmd_q.zero7);

  // R12: a waiting byte holds its value
  p_rx_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (rxv_q && !rx_ready) |=> (rxv_q && $stable(rxd_q)));

  // R12: shifting pauses while a byte waits
  p_pause_r12: assert property (@(posedge clk) disable iff (rst)
    (rxv_q && !rx_ready) |=> $stable(sclk_q));

endmodule

// File: tb/test_cmd_shift_engine.sv
module test_cmd_shift_engine;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int LEN_W = 16;
  localparam int DIV_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [7:0]       cmd_byte = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [DIV_W-1:0] cmd_div = '0;
  logic             tx_valid = 1'b0;
  logic             tx_ready;
  logic [W-1:0]     tx_data = '0;
  logic             rx_valid;
  logic             rx_ready = 1'b1;
  logic [W-1:0]     rx_data;
  logic             ser_clk, ser_out, ser_mode;
  logic             ser_in = 1'b0;

  cmd_shift_engine #(.W(W), .LEN_W(LEN_W), .DIV_W(DIV_W)) i_cmd_shift_engine (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
    .cmd_len(cmd_len), .cmd_div(cmd_div),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .ser_clk(ser_clk), .ser_out(ser_out), .ser_mode(ser_mode), .ser_in(ser_in)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // reference model state
  bit lf, cf, do_en, tms_en, stall, run_on;
  int nb = 8;
  int divv = 0;
  bit exp_out_q[$];
  bit sdi_q[$];
  logic [W-1:0] exp_rx_q[$];
  logic [W-1:0] tx_q[$];
  int tx_taken, edges, lvl_cnt, bib;
  bit low_exact;
  logic prev_sclk, prev_sdo, prev_stms;
  logic tx_hs, rx_hs, rx_pend;
  logic [W-1:0] rx_cap;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    tx_hs   <= tx_valid && tx_ready;
    rx_hs   <= rx_valid && rx_ready;
    rx_pend <= rx_valid && !rx_ready;
    rx_cap  <= rx_data;
  end

  always @(negedge clk) begin
    if (rst) begin
      prev_sclk = 1'b0;
      prev_sdo  = 1'b0;
      prev_stms = 1'b0;
      lvl_cnt   = 0;
    end else begin
      // outgoing byte stream
      if (tx_hs) begin
        if (tx_q.size() > 0) void'(tx_q.pop_front());
        tx_taken++;
      end
      tx_valid = (tx_q.size() > 0);
      tx_data  = tx_valid ? tx_q[0] : '0;
      // captured byte stream
      if (rx_hs) begin
        if (exp_rx_q.size() == 0) chk(1'b0, "R9", "unexpected rx byte", int'(rx_cap), 0);
        else begin
          logic [W-1:0] e;
          e = exp_rx_q.pop_front();
          chk(rx_cap == e, "R4/R5", "rx byte", int'(rx_cap), int'(e));
        end
      end
      rx_ready = stall ? (cyc % 3 == 0) : 1'b1;
      // R12: no clock movement while a byte waits
      if (rx_pend) chk(ser_clk == prev_sclk, "R12", "clock moved while stalled", int'(ser_clk), int'(prev_sclk));
      // R1: idle clock low
      if (cmd_ready) chk(ser_clk == 1'b0, "R1", "idle clock", int'(ser_clk), 0);
      // R8 / R10: disabled lines hold
      if (run_on && !do_en) chk(ser_out == prev_sdo, "R8", "data-out held", int'(ser_out), int'(prev_sdo));
      if (run_on && !tms_en) chk(ser_mode == prev_stms, "R10", "mode line held", int'(ser_mode), int'(prev_stms));
      // serial slave
      if (ser_clk !== prev_sclk) begin
        edges++;
        if (ser_clk) begin
          if (low_exact) chk(lvl_cnt == divv + 1, "R2", "low half width", lvl_cnt, divv + 1);
        end else begin
          chk(lvl_cnt == divv + 1, "R2", "high half width", lvl_cnt, divv + 1);
        end
        // sample outgoing bit on the edge opposite the launch edge
        if ((lf && ser_clk) || (!lf && !ser_clk)) begin
          if (exp_out_q.size() > 0) begin
            bit e;
            e = exp_out_q.pop_front();
            if (do_en)  chk(ser_out == e, "R3", "data-out bit", int'(ser_out), int'(e));
            if (tms_en) chk(ser_mode == e, "R10", "mode bit", int'(ser_mode), int'(e));
          end
        end
        // present next input bit on the edge opposite the capture edge
        if ((cf && ser_clk) || (!cf && !ser_clk)) begin
          if (sdi_q.size() > 0) ser_in = sdi_q.pop_front();
        end
        if (!ser_clk) begin
          bib++;
          if (bib == nb) begin
            bib = 0;
            low_exact = 1'b0;
          end else begin
            low_exact = 1'b1;
          end
        end
        lvl_cnt = 1;
      end else begin
        lvl_cnt++;
      end
      prev_sclk = ser_clk;
      prev_sdo  = ser_out;
      prev_stms = ser_mode;
    end
  end

  task automatic do_cmd(input logic [7:0] cb, input int len, input int dv,
                        input logic [7:0] seed, input bit stl);
    bit bitm, lsb, di_en, need;
    int nbytes;
    logic [W-1:0] mask;
    lf     = cb[0];
    bitm   = cb[1];
    cf     = cb[2];
    lsb    = cb[3];
    do_en  = cb[4];
    di_en  = cb[5];
    tms_en = cb[6];
    stall  = stl;
    divv   = dv;
    need   = (do_en || tms_en) && !cb[7];
    nb     = bitm ? (len % 8) + 1 : 8;
    nbytes = cb[7] ? 0 : (bitm ? 1 : len + 1);
    mask   = W'((1 << nb) - 1);
    exp_out_q.delete();
    sdi_q.delete();
    exp_rx_q.delete();
    tx_q.delete();
    for (int i = 0; i < nbytes; i++) begin
      logic [W-1:0] d, p;
      d = seed + W'(i * 8'h35);
      p = ~seed ^ W'(i * 8'h5B);
      if (need) tx_q.push_back(d);
      for (int kk = 0; kk < nb; kk++) begin
        int pos;
        pos = lsb ? kk : nb - 1 - kk;
        exp_out_q.push_back(d[pos]);
        sdi_q.push_back(p[pos]);
      end
      if (di_en) exp_rx_q.push_back(p & mask);
    end
    if (!need) tx_q.push_back(8'hC3);  // must never be taken
    tx_taken  = 0;
    edges     = 0;
    bib       = 0;
    low_exact = 1'b0;
    @(negedge clk);
    if (!cf && sdi_q.size() > 0) ser_in = sdi_q.pop_front();
    cmd_valid = 1'b1;
    cmd_byte  = cb;
    cmd_len   = LEN_W'(len);
    cmd_div   = DIV_W'(dv);
    run_on    = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int t = 0; t < 20000 && !cmd_ready; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    if (cb[7]) begin
      chk(edges == 0, "R11", "clock edges", edges, 0);
      chk(tx_taken == 0, "R11", "bytes taken", tx_taken, 0);
      chk(cmd_ready == 1'b1, "R11", "ready after drop", int'(cmd_ready), 1);
    end else begin
      chk(edges == 2 * nb * nbytes, bitm ? "R7" : "R6", "clock edges", edges, 2 * nb * nbytes);
      chk(exp_out_q.size() == 0, "R3", "bits left unsampled", exp_out_q.size(), 0);
      chk(exp_rx_q.size() == 0, "R9", "rx bytes missing", exp_rx_q.size(), 0);
      chk(tx_taken == (need ? nbytes : 0), "R10", "bytes taken", tx_taken, need ? nbytes : 0);
    end
    run_on = 1'b0;
    stall  = 1'b0;
    tx_q.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ser_clk == 1'b0, "R1", "reset clock", int'(ser_clk), 0);
    chk(rx_valid == 1'b0, "R1", "reset rx_valid", int'(rx_valid), 0);
    chk(cmd_ready == 1'b1, "R1", "reset cmd_ready", int'(cmd_ready), 1);
    // R3 R6: write, falling launch, MSB first, two bytes
    do_cmd(8'h11, 1, 1, 8'h3F, 1'b0);
    // R3: rising launch, one byte
    do_cmd(8'h10, 0, 0, 8'h55, 1'b0);
    // R4 R5 R9 R12: read-write, LSB first, rising capture, stalled output
    do_cmd(8'h39, 2, 2, 8'h96, 1'b1);
    // R4 R8 R10: read only, falling capture, stalled output
    do_cmd(8'h24, 1, 1, 8'h0F, 1'b1);
    // R7: bit mode, five bits, MSB first
    do_cmd(8'h32, 4, 0, 8'hB4, 1'b0);
    // R7: bit mode, upper length bits ignored, three bits LSB first
    do_cmd(8'h3A, 16'h0102, 1, 8'h6D, 1'b0);
    // R10: mode line only, seven bits LSB first
    do_cmd(8'h4A, 6, 3, 8'hE1, 1'b0);
    // R11: bit 7 set
    do_cmd(8'h91, 1, 0, 8'h77, 1'b0);
    // R2 R4: falling launch and capture, larger divisor
    do_cmd(8'h35, 0, 4, 8'h5A, 1'b0);
    // R10: both lines, full eight-bit bit mode, falling capture
    do_cmd(8'h76, 7, 0, 8'hC8, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule